// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between the execute stage of a 32-bit processor and a word-wide data memory. For every memory operation it adds a base register value to a signed 16-bit offset to form a byte address. It then turns that address into a word-aligned memory address plus the lane controls the memory needs. Stores produce per-byte write strobes and lane-replicated write data. Loads come back one cycle later. The aligner picks the addressed byte lane, then sign- or zero-extends that byte to 32 bits.

A parameter fixes how byte addresses map onto lanes inside a word. In the little-endian setting the lowest address is the least significant byte. In the big-endian setting it is the most significant byte. The word address is the same in both settings. Word operations whose address is not a multiple of four are flagged and suppressed.

The operation code `op` is encoded as follows: 0 is no access, 1 is word load, 2 is signed byte load, 3 is unsigned byte load, 4 is word store and 5 is byte store. Codes 6 and 7 are treated as no access. An operation is presented only when `req_valid` is high.

Top module: `byte_lane_aligner`

## Requirements
- R1: The byte address equals `base_addr` plus `offset` sign-extended to 32 bits, with wrap-around modulo 2^32. `mem_addr` carries that address with bits [1:0] forced to zero, in the same cycle.
- R2: A word load at an aligned address returns the whole memory word. In little-endian mode the byte at address A+k sits at bits [8k+7:8k]. In big-endian mode it sits at bits [31-8k:24-8k].
- R3: A byte access uses lane L = addr[1:0] in little-endian mode and L = 3 - addr[1:0] in big-endian mode, where lane L is bits [8L+7:8L] of the memory word. After 0x23456789 is stored at address 0, a byte load from address 1 yields 0x00000067 in little-endian mode and 0x00000045 in big-endian mode.
- R4: A signed byte load (code 2) copies bit 7 of the selected byte into result bits [31:8].
- R5: An unsigned byte load (code 3) places zeroes in result bits [31:8].
- R6: A byte store (code 5) raises exactly one of the four strobes `mem_we_strb`, with bit L for lane L as defined in R3. It drives the low 8 bits of `store_data` onto all four lanes of `mem_wdata`.
- R7: An aligned word store (code 4) raises all four strobes and drives `store_data` unchanged on `mem_wdata`.
- R8: A word load or word store whose address has bits [1:0] not zero raises `misalign` in the same cycle. It raises no strobe, does not assert `mem_rd`, and produces no `load_valid` in the next cycle.
- R9: `load_valid` is high exactly in the cycle after a cycle with `mem_rd` high. `mem_rd` is high for aligned word loads and for all byte loads. `load_data` is zero whenever `load_valid` is low.
- R10: Byte loads and byte stores never raise `misalign`, whatever the address bits [1:0] are.
- R11: With `req_valid` low, or with codes 0, 6 or 7, no strobe, no `mem_rd` and no `misalign` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation code (see encoding above) |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement from the instruction |
| store_data | input | 32 | Source register value for stores |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_rd | output | 1 | Memory read request |
| mem_we_strb | output | 4 | Per-lane write strobes, bit L for lane L |
| mem_wdata | output | 32 | Write data, lane-replicated for byte stores |
| misalign | output | 1 | Word operation at an unaligned address |
| mem_rdata | input | 32 | Memory read data, valid the cycle after `mem_rd` |
| load_valid | output | 1 | Load result present this cycle |
| load_data | output | 32 | Extended load result |

## Verification
The returning data of one load and the request of the following operation share a cycle. The lane chosen for the old load comes from registered state, while the strobes and address of the new operation come from the current inputs. The bench provokes this with back-to-back sequences: a word load is followed at once by a byte store into the same word, and then by a load of that word. The first result must show the contents from before the store, and the second must show the merged byte. Each result is judged against a byte-array reference model kept for both endian settings.

// File: rtl/lane_pkg.sv
package lane_pkg;
    localparam int unsigned LANES  = 4;
    localparam int unsigned LANE_W = $clog2(LANES);
    localparam int unsigned DATA_W = 8 * LANES;

    typedef enum logic [2:0] {
        ACC_NONE = 3'd0,
        ACC_LW   = 3'd1,
        ACC_LB   = 3'd2,
        ACC_LBU  = 3'd3,
        ACC_SW   = 3'd4,
        ACC_SB   = 3'd5
    } acc_op_e;

    typedef enum logic [1:0] {
        LD_WORD  = 2'd0,
        LD_SBYTE = 2'd1,
        LD_UBYTE = 2'd2
    } ld_kind_e;

    typedef struct packed {
        logic              pend;
        logic [LANE_W-1:0] lane;
        ld_kind_e          kind;
    } ld_state_t;
endpackage

// File: rtl/ea_adder.sv
module ea_adder #(
    parameter int unsigned AW = 32,
    parameter int unsigned OW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] disp,
    output logic [AW-1:0] ea
);
    localparam int unsigned EXT_W = AW - OW;

    logic [AW-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp[OW-1]}}, disp};
        ea       = base + disp_ext;
    end
endmodule

// File: rtl/store_lanes.sv
module store_lanes
    import lane_pkg::*;
(
    input  logic              do_word,
    input  logic              do_byte,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  strb,
    output logic [DATA_W-1:0] wdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        always_comb begin
            hit                = (lane == LANE_W'(g));
            strb[g]            = do_word | (do_byte & hit);
            wdata[g*8 +: 8]    = do_word ? src[g*8 +: 8] : src[7:0];
        end
    end
endmodule

// File: rtl/load_extract.sv
module load_extract
    import lane_pkg::*;
(
    input  logic              pend,
    input  logic [DATA_W-1:0] rdata,
    input  logic [LANE_W-1:0] lane,
    input  ld_kind_e          kind,
    output logic [DATA_W-1:0] result
);
    localparam int unsigned UPPER_W = DATA_W - 8;

    logic [7:0] lane_byte [LANES];
    logic [7:0] picked;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane_byte[g] = rdata[g*8 +: 8];
    end

    always_comb begin
        picked = lane_byte[lane];
        result = '0;
        if (pend) begin
            unique case (kind)
                LD_WORD:  result = rdata;
                LD_SBYTE: result = {{UPPER_W{picked[7]}}, picked};
                LD_UBYTE: result = {{UPPER_W{1'b0}}, picked};
                default:  result = '0;
            endcase
        end
    end
endmodule

// File: rtl/byte_lane_aligner.sv
module byte_lane_aligner
    import lane_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned OW         = 16,
    parameter bit          BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        op,
    input  logic [AW-1:0]     base_addr,
    input  logic [OW-1:0]     offset,
    input  logic [DATA_W-1:0] store_data,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic [LANES-1:0]  mem_we_strb,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              misalign,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_data
);
    localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

    acc_op_e           acc;
    logic [AW-1:0]     ea;
    logic [LANE_W-1:0] lane;
    logic              is_word, is_load, is_byte;
    logic              do_sw, do_sb;
    ld_state_t         st_d, st_q;

    ea_adder #(.AW(AW), .OW(OW)) u_ea (
        .base (base_addr),
        .disp (offset),
        .ea   (ea)
    );

    always_comb begin
        acc      = acc_op_e'(op);
        is_word  = req_valid & ((acc == ACC_LW) | (acc == ACC_SW));
        is_byte  = req_valid & ((acc == ACC_LB) | (acc == ACC_LBU) | (acc == ACC_SB));
        is_load  = req_valid & ((acc == ACC_LW) | (acc == ACC_LB) | (acc == ACC_LBU));
        misalign = is_word & (ea[LANE_W-1:0] != '0);
        if (BIG_ENDIAN) lane = TOP_LANE - ea[LANE_W-1:0];
        else            lane = ea[LANE_W-1:0];
        do_sw    = req_valid & (acc == ACC_SW) & ~misalign;
        do_sb    = req_valid & (acc == ACC_SB);
        mem_rd   = is_load & ~misalign;
        mem_addr = {ea[AW-1:LANE_W], {LANE_W{1'b0}}};

        st_d.pend = mem_rd;
        st_d.lane = lane;
        if (acc == ACC_LB)       st_d.kind = LD_SBYTE;
        else if (acc == ACC_LBU) st_d.kind = LD_UBYTE;
        else                     st_d.kind = LD_WORD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{pend: 1'b0, lane: '0, kind: LD_WORD};
        else        st_q <= st_d;
    end

    store_lanes u_st (
        .do_word (do_sw),
        .do_byte (do_sb),
        .lane    (lane),
        .src     (store_data),
        .strb    (mem_we_strb),
        .wdata   (mem_wdata)
    );

    load_extract u_ld (
        .pend   (st_q.pend),
        .rdata  (mem_rdata),
        .lane   (st_q.lane),
        .kind   (st_q.kind),
        .result (load_data)
    );

    assign load_valid = st_q.pend;

    p_sb_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == 3'd5) |-> $countones(mem_we_strb) == 1);

    p_misal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_we_strb == '0 && !mem_rd));

    p_misal_no_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> !load_valid);

    p_result_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> load_valid);

    p_no_stray_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |=> (!load_valid && load_data == '0));

    p_byte_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_byte |-> !misalign);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (mem_we_strb == '0 && !mem_rd && !misalign));

    p_sext_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && st_q.kind == LD_SBYTE) |->
            load_data[DATA_W-1:8] == {(DATA_W-8){load_data[7]}});

    p_zext_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && st_q.kind == LD_UBYTE) |-> load_data[DATA_W-1:8] == '0);
endmodule

// File: tb/byte_lane_aligner_test.sv
module byte_lane_aligner_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] base_addr = '0;
    logic [15:0] offset = '0;
    logic [31:0] store_data = '0;

    logic [31:0] mem_addr   [2];
    logic        mem_rd     [2];
    logic [3:0]  strb       [2];
    logic [31:0] wdata      [2];
    logic        misal      [2];
    logic [31:0] rdata      [2];
    logic        ld_v       [2];
    logic [31:0] ld_d       [2];

    logic [31:0] wmem   [2][16];
    logic [7:0]  refmem [2][64];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit          pend_exp  [2];
    logic [31:0] pend_data [2];

    always #5 clk = ~clk;

    byte_lane_aligner #(.BIG_ENDIAN(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
        .base_addr(base_addr), .offset(offset), .store_data(store_data),
        .mem_addr(mem_addr[0]), .mem_rd(mem_rd[0]), .mem_we_strb(strb[0]),
        .mem_wdata(wdata[0]), .misalign(misal[0]), .mem_rdata(rdata[0]),
        .load_valid(ld_v[0]), .load_data(ld_d[0]));

    byte_lane_aligner #(.BIG_ENDIAN(1'b1)) uut_be (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
        .base_addr(base_addr), .offset(offset), .store_data(store_data),
        .mem_addr(mem_addr[1]), .mem_rd(mem_rd[1]), .mem_we_strb(strb[1]),
        .mem_wdata(wdata[1]), .misalign(misal[1]), .mem_rdata(rdata[1]),
        .load_valid(ld_v[1]), .load_data(ld_d[1]));

    always @(posedge clk) begin
        for (int e = 0; e < 2; e++) begin
            for (int k = 0; k < 4; k++)
                if (strb[e][k]) wmem[e][mem_addr[e][5:2]][k*8 +: 8] <= wdata[e][k*8 +: 8];
            rdata[e] <= wmem[e][mem_addr[e][5:2]];
        end
    end

    task automatic chk(input string req, input int e, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s) actual=%h expected=%h", req, e ? "big" : "little", act, exp);
        end
    endtask

    function automatic logic [31:0] ref_load(input int e, input logic [2:0] code, input logic [5:0] a);
        logic [7:0] b;
        logic [5:0] w;
        w = {a[5:2], 2'b00};
        b = refmem[e][a];
        if (code == 3'd1)
            return e ? {refmem[e][w], refmem[e][w+1], refmem[e][w+2], refmem[e][w+3]}
                     : {refmem[e][w+3], refmem[e][w+2], refmem[e][w+1], refmem[e][w]};
        if (code == 3'd2) return {{24{b[7]}}, b};
        return {24'h0, b};
    endfunction

    task automatic check_results(input string req);
        for (int e = 0; e < 2; e++) begin
            chk({req, " R9 valid"}, e, {31'h0, ld_v[e]}, {31'h0, pend_exp[e]});
            chk({req, " data"}, e, ld_d[e], pend_exp[e] ? pend_data[e] : 32'h0);
        end
    endtask

    // Drive one operation at a falling edge; check the previous load result first.
    task automatic do_op(input string req, input logic v, input logic [2:0] code,
                         input logic [31:0] b, input logic [15:0] d, input logic [31:0] src);
        logic [31:0] ea;
        logic        word, bytea, ld, mis;
        logic [1:0]  ln;
        logic [3:0]  es;
        logic [31:0] ew;
        @(negedge clk);
        check_results(req);
        req_valid = v; op = code; base_addr = b; offset = d; store_data = src;
        #1;
        ea    = b + {{16{d[15]}}, d};
        word  = v && (code == 3'd1 || code == 3'd4);
        bytea = v && (code == 3'd2 || code == 3'd3 || code == 3'd5);
        ld    = v && (code == 3'd1 || code == 3'd2 || code == 3'd3);
        mis   = word && (ea[1:0] != 2'b00);
        for (int e = 0; e < 2; e++) begin
            ln = e ? 2'd3 - ea[1:0] : ea[1:0];
            es = 4'h0; ew = wdata[e];
            if (v && code == 3'd4 && !mis) begin es = 4'hF; ew = src; end
            if (v && code == 3'd5) begin es = 4'h1 << ln; ew = {4{src[7:0]}}; end
            chk("R1 addr", e, mem_addr[e], {ea[31:2], 2'b00});
            chk("R8/R10/R11 misalign", e, {31'h0, misal[e]}, {31'h0, mis});
            chk("R6/R7/R8/R11 strobes", e, {28'h0, strb[e]}, {28'h0, es});
            chk("R6/R7 wdata", e, wdata[e], ew);
            chk("R9 rd", e, {31'h0, mem_rd[e]}, {31'h0, ld && !mis});
            pend_exp[e] = ld && !mis;
            pend_data[e] = pend_exp[e] ? ref_load(e, code, ea[5:0]) : 32'h0;
            if (v && code == 3'd4 && !mis)
                for (int k = 0; k < 4; k++)
                    refmem[e][{ea[5:2], 2'(k)}] = e ? src[31-8*k -: 8] : src[8*k +: 8];
            if (v && code == 3'd5) refmem[e][ea[5:0]] = src[7:0];
        end
        if (bytea && mis) $display("note: unexpected flag model state");
    endtask

    initial begin
        for (int e = 0; e < 2; e++) begin
            pend_exp[e] = 1'b0; pend_data[e] = '0;
            for (int i = 0; i < 16; i++) wmem[e][i] = '0;
            for (int i = 0; i < 64; i++) refmem[e][i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int e = 0; e < 2; e++) begin
            chk("reset R9", e, {31'h0, ld_v[e]}, 32'h0);
            chk("reset R11", e, {28'h0, strb[e]}, 32'h0);
        end
        rst_n = 1'b1;
        // R7 R1: word store with negative offset
        do_op("R7", 1, 3'd4, 32'h0000_0020, 16'hFFE0, 32'h2345_6789);
        // R3: the stated endian example
        do_op("R3", 1, 3'd3, 32'h0, 16'h0001, 32'h0);
        do_op("R2", 1, 3'd1, 32'h0, 16'h0000, 32'h0);
        // R4 R5 on all four lanes
        do_op("R7", 1, 3'd4, 32'h0000_0004, 16'h0000, 32'h80F1_7F02);
        for (int k = 0; k < 4; k++) begin
            do_op("R4", 1, 3'd2, 32'h0000_0004, 16'(k), 32'h0);
            do_op("R5", 1, 3'd3, 32'h0000_0004, 16'(k), 32'h0);
        end
        // R1 wrap-around address
        do_op("R1", 1, 3'd4, 32'hFFFF_FFF0, 16'h0020, 32'hCAFE_F00D);
        do_op("R2", 1, 3'd1, 32'h0000_0010, 16'h0000, 32'h0);
        // R6 byte store every lane
        for (int k = 0; k < 4; k++)
            do_op("R6", 1, 3'd5, 32'h0000_0008, 16'(k), 32'h1234_5600 + 32'(k * 17 + 160));
        do_op("R6", 1, 3'd1, 32'h0000_0008, 16'h0000, 32'h0);
        // R8 misaligned word store and load
        do_op("R8", 1, 3'd4, 32'h0000_000C, 16'h0001, 32'hDEAD_BEEF);
        do_op("R8", 1, 3'd1, 32'h0000_000C, 16'h0000, 32'h0);
        do_op("R8", 1, 3'd1, 32'h0000_000C, 16'h0002, 32'h0);
        do_op("R8", 1, 3'd4, 32'h0000_000C, 16'h0003, 32'hDEAD_BEEF);
        // R10 byte access at unaligned address
        do_op("R10", 1, 3'd5, 32'h0000_000C, 16'h0003, 32'h0000_0099);
        do_op("R10", 1, 3'd2, 32'h0000_000C, 16'h0003, 32'h0);
        // R11 idle and unused codes
        do_op("R11", 0, 3'd4, 32'h0000_000C, 16'h0000, 32'h1111_1111);
        do_op("R11", 1, 3'd6, 32'h0000_000C, 16'h0000, 32'h1111_1111);
        do_op("R11", 1, 3'd7, 32'h0000_000C, 16'h0000, 32'h1111_1111);
        do_op("R11", 1, 3'd0, 32'h0000_000C, 16'h0000, 32'h1111_1111);
        do_op("R11", 1, 3'd1, 32'h0000_000C, 16'h0000, 32'h0);
        // Overlap: load then byte store into the same word, then reload
        do_op("R9", 1, 3'd1, 32'h0000_0000, 16'h0000, 32'h0);
        do_op("R9", 1, 3'd5, 32'h0000_0000, 16'h0002, 32'h0000_005A);
        do_op("R9", 1, 3'd1, 32'h0000_0000, 16'h0000, 32'h0);
        do_op("R9", 1, 3'd2, 32'h0000_0000, 16'h0002, 32'h0);
        do_op("R9", 0, 3'd0, 32'h0, 16'h0, 32'h0);
        do_op("R9", 0, 3'd0, 32'h0, 16'h0, 32'h0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule